// File: doc/BRIEF.md
# Burst-of-Two Separate-I/O Synchronous SRAM Core

This block is a cycle-accurate, synthesizable model of a synchronous static memory with a read port and a write port that operate independently. Every access moves a pair of words. A read command and a write command may both be accepted in the same input-clock cycle, and the two directions never share a bus.

The whole block runs from one clock at twice the input-clock rate. The `kHalf` input tells the block which half-cycle each edge stands for: 0 marks a K rising edge and 1 marks a K# rising edge. The output-clock phase comes in on `cPhase`. The `cHeld` input stands for both output clocks being tied high; in that case output timing follows the input clocks.

Writes go through a one-entry write buffer. The first data half arrives with the command, and the address and second data half arrive half a cycle later. A read always returns the most recent data, even when that data is still in the buffer, and it merges byte lanes as needed. The depth and the lane geometry are parameters, and so is the read latency.

Top module: `qsram_b2`

## Requirements
- R1: A read and a write may be accepted on the same K edge. The read then returns the contents from before that write.
- R2: Each read produces exactly two output beats. Beat 0 carries word {addr,0} with `rdBeat`=0, and beat 1 carries word {addr,1} with `rdBeat`=1.
- R3: `rdReq` and `wrReq` are sampled only on edges with `kHalf`=0, and `addr` is taken there as the read address. On the next edge with `kHalf`=1, `addr` is taken as the write address. Commands asserted while `kHalf`=1 have no effect.
- R4: `wrData`/`wrBe` on the K edge that carries `wrReq` form beat 0 of the write, and the values on the following K# edge form beat 1.
- R5: `wrBe` bit i is active high and controls bits [9i+8:9i] of the word for its beat. A lane whose bit is 0 keeps its old contents.
- R6: With `RD_LAT`=2 (1.5-cycle mode), beat 0 is launched on the second output-clock C# edge after the read command, and beat 1 on the next C edge. `RD_LAT`=3 (2.5-cycle mode) adds one full cycle. An edge counts as a C# edge when `cPhase`=1.
- R7: While `cHeld`=1, `cPhase` is ignored and edges with `kHalf`=1 count as C# edges.
- R8: A read issued on the K edge right after a write to the same address returns the newly written lanes merged with the old lanes.
- R9: Reset clears the outstanding reads and the write buffer, so `rdValid` stays 0 until a new read has run its course. It leaves the array contents unchanged.
- R10: `rdValid` is high for exactly one edge per beat and low on every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; each edge is one half of the input clock |
| rst | input | 1 | Synchronous active-high reset |
| kHalf | input | 1 | 0 = this edge is a K rise, 1 = a K# rise |
| cPhase | input | 1 | 1 = this edge is a C# rise, 0 = a C rise |
| cHeld | input | 1 | Output clocks tied high; time output from K/K# |
| rdReq | input | 1 | Read command (sampled on K) |
| wrReq | input | 1 | Write command (sampled on K) |
| addr | input | AW-1 | Read address on K, write address on K# |
| wrData | input | 18 | Write data beat |
| wrBe | input | 2 | Active-high byte-lane enables for the beat |
| rdData | output | 18 | Read data beat |
| rdValid | output | 1 | Beat on rdData is valid |
| rdBeat | output | 1 | 0 = first beat, 1 = second beat |

## Verification
The bench first targets the half-cycle skew between write data and write address. It places a read of the just-written address on the very next K edge. A design that reads the array without looking at the buffer returns stale lanes there, and one that latches the address on the wrong half corrupts a neighbouring pair. All sixteen byte-enable combinations across both beats are applied, which exposes swapped lanes or swapped beats. Reads run under aligned, inverted and tied-high output clocks in both latency modes, so a wrong edge count shows up as a beat one half-cycle early or late. The bench also asserts commands during K# slots and resets the block with reads still in flight; a model that leaks either one produces unexpected valid beats.

// File: rtl/qsram_pkg.sv
package qsram_pkg;
  localparam int QD  = 4;
  localparam int QIW = $clog2(QD);

  typedef struct packed {
    logic           bufFill0;
    logic           bufFill1;
    logic           bufLive;
    logic           commit;
    logic           rdAlloc;
    logic [QIW-1:0] allocIdx;
    logic           launch0;
    logic           launch1;
    logic [QIW-1:0] headIdx;
  } qsCtl_t;
endpackage

// File: rtl/qsram_ctrl.sv
module qsram_ctrl
  import qsram_pkg::*;
#(
  parameter int RD_LAT = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   kHalf,
  input  logic   cPhase,
  input  logic   cHeld,
  input  logic   rdReq,
  input  logic   wrReq,
  output qsCtl_t ctl
);
  localparam int CW = $clog2(RD_LAT + 1);

  logic kEdge, cshEdge;
  logic wrArmed, bufValid;
  logic [QIW-1:0] wp, rp;
  logic busy [QD];
  logic sent [QD];
  logic [CW-1:0] cnt [QD];

  assign kEdge   = !kHalf;
  assign cshEdge = cHeld ? kHalf : cPhase;

  always_comb begin
    ctl          = '0;
    ctl.bufFill0 = kEdge & wrReq;
    ctl.bufFill1 = !kEdge & wrArmed;
    ctl.bufLive  = bufValid;
    ctl.commit   = kEdge & bufValid;
    ctl.rdAlloc  = kEdge & rdReq;
    ctl.allocIdx = wp;
    ctl.headIdx  = rp;
    ctl.launch0  = busy[rp] & !sent[rp] & cshEdge & (cnt[rp] <= CW'(1));
    ctl.launch1  = busy[rp] & sent[rp] & !cshEdge;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrArmed  <= 1'b0;
      bufValid <= 1'b0;
    end else if (kEdge) begin
      wrArmed  <= wrReq;
      bufValid <= 1'b0;
    end else if (wrArmed) begin
      wrArmed  <= 1'b0;
      bufValid <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (ctl.rdAlloc) wp <= wp + 1'b1;
      if (ctl.launch1) rp <= rp + 1'b1;
    end
  end

  for (genvar i = 0; i < QD; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        busy[i] <= 1'b0;
        sent[i] <= 1'b0;
        cnt[i]  <= '0;
      end else if (ctl.rdAlloc && wp == QIW'(i)) begin
        busy[i] <= 1'b1;
        sent[i] <= 1'b0;
        cnt[i]  <= CW'(RD_LAT);
      end else if (busy[i]) begin
        if (cshEdge && cnt[i] != '0) cnt[i] <= cnt[i] - 1'b1;
        if (ctl.launch0 && rp == QIW'(i)) sent[i] <= 1'b1;
        if (ctl.launch1 && rp == QIW'(i)) busy[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/qsram_dpath.sv
module qsram_dpath
  import qsram_pkg::*;
#(
  parameter int AW = 5,
  parameter int LW = 9,
  parameter int NL = 2,
  parameter int DW = NL * LW
) (
  input  logic          clk,
  input  logic          rst,
  input  qsCtl_t        ctl,
  input  logic [AW-2:0] addr,
  input  logic [DW-1:0] wrData,
  input  logic [NL-1:0] wrBe,
  output logic [DW-1:0] rdData,
  output logic          rdValid,
  output logic          rdBeat
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] h0Data;
  logic [NL-1:0] h0Be;
  logic [AW-2:0] bAddr;
  logic [DW-1:0] bData [2];
  logic [NL-1:0] bBe [2];
  logic [DW-1:0] eData [QD][2];
  logic [DW-1:0] rdWord [2];
  logic          bufHit;

  assign bufHit = ctl.bufLive && (bAddr == addr);

  for (genvar b = 0; b < 2; b++) begin : g_beat
    for (genvar l = 0; l < NL; l++) begin : g_lane
      assign rdWord[b][l*LW +: LW] = (bufHit && bBe[b][l]) ? bData[b][l*LW +: LW]
                                                         : mem[{addr, 1'(b)}][l*LW +: LW];
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.bufFill0) begin
      h0Data <= wrData;
      h0Be   <= wrBe;
    end
    if (ctl.bufFill1) begin
      bAddr    <= addr;
      bData[0] <= h0Data;
      bBe[0]   <= h0Be;
      bData[1] <= wrData;
      bBe[1]   <= wrBe;
    end
    if (ctl.commit) begin
      for (int b = 0; b < 2; b++) begin
        for (int l = 0; l < NL; l++) begin
          if (bBe[b][l]) mem[{bAddr, 1'(b)}][l*LW +: LW] <= bData[b][l*LW +: LW];
        end
      end
    end
    if (ctl.rdAlloc) begin
      eData[ctl.allocIdx][0] <= rdWord[0];
      eData[ctl.allocIdx][1] <= rdWord[1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdValid <= 1'b0;
      rdBeat  <= 1'b0;
    end else begin
      rdValid <= ctl.launch0 | ctl.launch1;
      rdBeat  <= ctl.launch1;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.launch0 | ctl.launch1) rdData <= eData[ctl.headIdx][ctl.launch1];
  end
endmodule

// File: rtl/qsram_b2.sv
module qsram_b2
  import qsram_pkg::*;
#(
  parameter int AW     = 5,
  parameter int LW     = 9,
  parameter int NL     = 2,
  parameter int RD_LAT = 2,
  parameter int DW     = NL * LW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          kHalf,
  input  logic          cPhase,
  input  logic          cHeld,
  input  logic          rdReq,
  input  logic          wrReq,
  input  logic [AW-2:0] addr,
  input  logic [DW-1:0] wrData,
  input  logic [NL-1:0] wrBe,
  output logic [DW-1:0] rdData,
  output logic          rdValid,
  output logic          rdBeat
);
  qsCtl_t ctl;

  qsram_ctrl #(.RD_LAT(RD_LAT)) u_ctrl (
    .clk(clk), .rst(rst), .kHalf(kHalf), .cPhase(cPhase), .cHeld(cHeld),
    .rdReq(rdReq), .wrReq(wrReq), .ctl(ctl)
  );

  qsram_dpath #(.AW(AW), .LW(LW), .NL(NL), .DW(DW)) u_dpath (
    .clk(clk), .rst(rst), .ctl(ctl), .addr(addr), .wrData(wrData), .wrBe(wrBe),
    .rdData(rdData), .rdValid(rdValid), .rdBeat(rdBeat)
  );
endmodule

// File: rtl/qsram_b2_chk.sv
module qsram_b2_chk (
  input logic clk,
  input logic rst,
  input logic kHalf,
  input logic cPhase,
  input logic cHeld,
  input logic rdValid,
  input logic rdBeat
);
  logic outCsh;
  assign outCsh = cHeld ? kHalf : cPhase;

  AST_FIRST_BEAT_ON_CSH: assert property (@(posedge clk) disable iff (rst)
    rdValid && !rdBeat |-> $past(outCsh)); // R6
  AST_SECOND_BEAT_ON_C: assert property (@(posedge clk) disable iff (rst)
    rdValid && rdBeat |-> !$past(outCsh)); // R7
  AST_BEAT_PAIRING: assert property (@(posedge clk) disable iff (rst)
    rdValid && rdBeat |-> $past(rdValid && !rdBeat)); // R2
  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !rdValid); // R9
endmodule

bind qsram_b2 qsram_b2_chk u_chk (
  .clk(clk), .rst(rst), .kHalf(kHalf), .cPhase(cPhase), .cHeld(cHeld),
  .rdValid(rdValid), .rdBeat(rdBeat)
);

// File: tb/sim_qsram_b2.sv
module sim_qsram_b2;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic kHalf = 1'b0, cPhase = 1'b0, cHeld = 1'b0;
  logic rdReq = 1'b0, wrReq = 1'b0;
  logic [3:0] addr = '0;
  logic [17:0] wrData = '0;
  logic [1:0] wrBe = '0;
  logic [17:0] rdData0, rdData1;
  logic rdValid0, rdValid1, rdBeat0, rdBeat1;

  int checks = 0, fails = 0, ec = 0, mode = 0;
  bit live = 0, noise = 0, finished = 0;
  logic [17:0] model [32];
  bit expV [2][64];
  bit expB [2][64];
  logic [17:0] expD [2][64];

  always #2 clk = ~clk;
  always @(posedge clk) ec++;

  qsram_b2 #(.RD_LAT(2)) u0 (.clk(clk), .rst(rst), .kHalf(kHalf), .cPhase(cPhase), .cHeld(cHeld),
    .rdReq(rdReq), .wrReq(wrReq), .addr(addr), .wrData(wrData), .wrBe(wrBe),
    .rdData(rdData0), .rdValid(rdValid0), .rdBeat(rdBeat0));
  qsram_b2 #(.RD_LAT(3)) u1 (.clk(clk), .rst(rst), .kHalf(kHalf), .cPhase(cPhase), .cHeld(cHeld),
    .rdReq(rdReq), .wrReq(wrReq), .addr(addr), .wrData(wrData), .wrBe(wrBe),
    .rdData(rdData1), .rdValid(rdValid1), .rdBeat(rdBeat1));

  // Monitor: R2 R6 R7 R8 R10 beats appear exactly where scheduled, nowhere else (R3 noise too)
  always @(negedge clk) begin
    if (live) begin
      for (int u = 0; u < 2; u++) begin
        logic v, bt;
        logic [17:0] d;
        int idx;
        idx = ec % 64;
        v  = (u == 0) ? rdValid0 : rdValid1;
        bt = (u == 0) ? rdBeat0 : rdBeat1;
        d  = (u == 0) ? rdData0 : rdData1;
        checks++;
        if (expV[u][idx]) begin
          if (!(v && bt == expB[u][idx] && d == expD[u][idx])) begin
            fails++;
            $display("FAIL R2 R6 R8 dut%0d edge %0d: valid=%0d beat=%0d data=%h expected valid=1 beat=%0d data=%h",
                     u, ec, v, bt, d, expB[u][idx], expD[u][idx]);
          end
        end else if (v) begin
          fails++;
          $display("FAIL R3 R10 dut%0d edge %0d: valid=1 beat=%0d expected valid=0", u, ec, bt);
        end
        expV[u][idx] = 0;
      end
    end
  end

  task automatic drive(input logic h, input logic r, input logic w, input logic [3:0] a,
                       input logic [17:0] d, input logic [1:0] be);
    @(negedge clk);
    kHalf = h; rdReq = r; wrReq = w; addr = a; wrData = d; wrBe = be;
    cHeld  = (mode == 1);
    cPhase = (mode == 2) ? !h : ((mode == 1) ? 1'b0 : h);
  endtask

  task automatic sched(input int e, input logic [3:0] a);
    for (int u = 0; u < 2; u++) begin
      for (int b = 0; b < 2; b++) begin
        int t;
        t = e + 2 * (u + 2) - 1 + ((mode == 2) ? 1 : 0) + b;
        expV[u][t % 64] = 1;
        expB[u][t % 64] = b[0];
        expD[u][t % 64] = model[{a, b[0]}];
      end
    end
  endtask

  // One K cycle: K slot (commands, read addr, beat 0) then K# slot (write addr, beat 1). R4
  task automatic kcyc(input logic r, input logic [3:0] ra, input logic w, input logic [3:0] wa,
                      input logic [17:0] d0, input logic [1:0] be0,
                      input logic [17:0] d1, input logic [1:0] be1);
    drive(1'b0, r, w, ra, d0, be0);
    if (r) sched(ec + 1, ra);
    drive(1'b1, noise ? 1'($urandom_range(0, 1)) : 1'b0,
          noise ? 1'($urandom_range(0, 1)) : 1'b0, wa, d1, be1);
    if (w) begin
      for (int l = 0; l < 2; l++) begin // R5 lane l = bits [9l+8:9l]
        if (be0[l]) model[{wa, 1'b0}][l*9 +: 9] = d0[l*9 +: 9];
        if (be1[l]) model[{wa, 1'b1}][l*9 +: 9] = d1[l*9 +: 9];
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) kcyc(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic doReset();
    live = 0;
    @(negedge clk);
    rst = 1; rdReq = 0; wrReq = 0;
    repeat (4) drive(!kHalf, 0, 0, 0, 0, 0);
    for (int u = 0; u < 2; u++) for (int i = 0; i < 64; i++) expV[u][i] = 0;
    drive(1'b1, 0, 0, 0, 0, 0);
    rst = 0;
    live = 1;
  endtask

  task automatic randomRun(input int n);
    for (int i = 0; i < n; i++)
      kcyc(1'($urandom_range(0, 1)), 4'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
           4'($urandom_range(0, 3)), 18'($urandom), 2'($urandom_range(0, 3)),
           18'($urandom), 2'($urandom_range(0, 3)));
    idle(6);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    doReset();
    // R9: reset state
    @(negedge clk);
    checks++;
    if (rdValid0 || rdValid1) begin
      fails++;
      $display("FAIL R9 reset state: valid=%0d/%0d expected 0/0", rdValid0, rdValid1);
    end
    // Fill every pair with full lanes, then read all back (R2 R4)
    for (int a = 0; a < 16; a++)
      kcyc(0, 0, 1, 4'(a), 18'(a * 1111 + 7), 2'b11, 18'(a * 2333 + 5), 2'b11);
    for (int a = 0; a < 16; a++) kcyc(1, 4'(a), 0, 0, 0, 0, 0, 0);
    idle(6);
    // R5 R8: every enable pattern on both beats, read on the very next K edge
    for (int a = 0; a < 4; a++)
      for (int m = 0; m < 16; m++) begin
        kcyc(0, 0, 1, 4'(a), 18'($urandom), 2'(m), 18'($urandom), 2'(m >> 2));
        kcyc(1, 4'(a), 0, 0, 0, 0, 0, 0);
      end
    idle(6);
    // R1: read and write the same pair in one K cycle, then read again
    kcyc(1, 4'd9, 1, 4'd9, 18'h15a5a, 2'b11, 18'h0a5a5, 2'b11);
    kcyc(1, 4'd9, 0, 0, 0, 0, 0, 0);
    idle(6);
    // R3 noise on K# slots, R6 R7 across three output-clock modes
    noise = 1;
    for (int md = 0; md < 3; md++) begin
      mode = md;
      idle(2);
      randomRun(300);
      for (int a = 0; a < 16; a++) kcyc(1, 4'(a), 0, 0, 0, 0, 0, 0);
      idle(6);
    end
    noise = 0;
    mode = 0;
    // R9: reads in flight are dropped by reset, array retained
    kcyc(1, 4'd3, 0, 0, 0, 0, 0, 0);
    doReset();
    idle(6);
    for (int a = 0; a < 16; a++) kcyc(1, 4'(a), 0, 0, 0, 0, 0, 0);
    idle(6);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule